// File: doc/BRIEF.md
# Translation Fault Status Recorder

This block sits beside an address translation unit and keeps a record of synchronous translation faults for software to inspect. Each time the translation logic reports a fault, the block packs the fault's walk level, access type, fault type, external bus error bits and address-valid flag into a 32-bit status word. It also stores the faulting virtual address in a separate address register. Both registers are visible through a simple register read port.

If a second fault arrives before software has read the status word, the newest fault overwrites every field and an overwrite flag is set. Software can then tell that the earlier fault was lost. Reading the status word returns its value and clears it on the following clock edge.

The block also decides whether a fault interrupts the processor. Normally every fault produces a one-cycle trap pulse. When the quiet-mode bit (bit 1 of the control word) is set, faults are still recorded but no trap is raised. The one exception is an access made through address space identifier 9, which traps regardless of the quiet-mode bit.

Top module: `fault_capture`

## Requirements
- R1: After reset the status word and the address register both read 0, and `trap` is 0.
- R2: A captured fault is packed into the status word as follows: bits [31:18] are 0, [17:10] hold the bus error bits, [9:8] the level, [7:5] the access type (0 user data load through 7 supervisor instruction store), [4:2] the fault type (0 none, 1 invalid address, 2 protection, 3 privilege, 4 translation, 5 bus access, 6 internal, 7 reserved), and bit 1 holds the address-valid flag.
- R3: Every captured fault loads `flt_addr` into the address register, which is read with `rd_sel`=1.
- R4: With control bit 1 at 0, a fault produces a `trap` pulse that is high in the cycle after capture only.
- R5: With control bit 1 at 1 and an ASI other than 9, a fault updates both registers but `trap` stays 0.
- R6: With control bit 1 at 1 and an ASI equal to 9, a fault still raises the `trap` pulse.
- R7: A fault that arrives while an earlier fault is still unread overwrites all fields with the new fault and sets bit 0 (overwrite).
- R8: A status read (`rd_en`=1, `rd_sel`=0) returns the current status combinationally. The status word, including the overwrite bit, becomes 0 after that clock edge. The address register is unchanged by the read.
- R9: A fault that coincides with a status read is captured with overwrite 0 and counts as unread, so the next unread fault sets overwrite.
- R10: A read of the address register (`rd_sel`=1) leaves the status word and its unread state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault event strobe |
| flt_level | input | 2 | Table walk level of the fault |
| flt_acc | input | 3 | Access type code |
| flt_kind | input | 3 | Fault type code |
| flt_bus | input | 8 | External bus error bits |
| flt_addr | input | 32 | Faulting virtual address |
| flt_addr_ok | input | 1 | Address is valid for this fault |
| flt_asi | input | 8 | Address space identifier of the access |
| ctl_reg | input | 32 | Control word; bit 1 is the quiet-mode bit |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 selects status, 1 selects address |
| rd_data | output | 32 | Read data |
| trap | output | 1 | One-cycle trap request |

## Verification
The hardest situation to reach from the ports is a fault and a status read landing on the same clock edge. That must be followed by a second fault to show that the coincident one was counted as unread. The stimulus drives `rd_en` together with `flt_valid` for exactly one cycle and then issues a further fault with no read in between. A long pseudo-random phase also mixes reads, faults, ASI 9 and the quiet-mode bit on every cycle. In that phase the per-cycle reference model catches any ordering slip between clearing and overwriting.

// File: rtl/fault_capture.sv
module fault_capture #(
  parameter int AW       = 32,
  parameter int ASI_W    = 8,
  parameter int BUS_W    = 8,
  parameter int TRAP_ASI = 9,
  parameter int QUIET_B  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_valid,
  input  logic [1:0]       flt_level,
  input  logic [2:0]       flt_acc,
  input  logic [2:0]       flt_kind,
  input  logic [BUS_W-1:0] flt_bus,
  input  logic [AW-1:0]    flt_addr,
  input  logic             flt_addr_ok,
  input  logic [ASI_W-1:0] flt_asi,
  input  logic [31:0]      ctl_reg,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [31:0]      rd_data,
  output logic             trap
);
  localparam int FW  = BUS_W + 10;
  localparam int PAD = 32 - FW;

  logic [FW-1:0] fsr;
  logic [AW-1:0] far;
  logic          unread;

  wire st_read  = rd_en && !rd_sel;
  wire quiet    = ctl_reg[QUIET_B];
  wire asi_hit  = flt_asi == ASI_W'(TRAP_ASI);
  wire ow_next  = unread && !st_read;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr    <= '0;
      far    <= '0;
      unread <= 1'b0;
      trap   <= 1'b0;
    end else begin
      trap <= flt_valid && (!quiet || asi_hit);
      if (flt_valid) begin
        fsr    <= {flt_bus, flt_level, flt_acc, flt_kind, flt_addr_ok, ow_next};
        far    <= flt_addr;
        unread <= 1'b1;
      end else if (st_read) begin
        fsr    <= '0;
        unread <= 1'b0;
      end
    end
  end

  wire [31:0] fsr_word = {{PAD{1'b0}}, fsr};
  wire [31:0] far_word = 32'(far);

  assign rd_data = rd_sel ? far_word : fsr_word;
endmodule

// File: rtl/fault_capture_chk.sv
module fault_capture_chk #(
  parameter int AW       = 32,
  parameter int ASI_W    = 8,
  parameter int TRAP_ASI = 9,
  parameter int QUIET_B  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flt_valid,
  input logic [AW-1:0]    flt_addr,
  input logic             flt_addr_ok,
  input logic [ASI_W-1:0] flt_asi,
  input logic [31:0]      ctl_reg,
  input logic             rd_en,
  input logic             rd_sel,
  input logic [31:0]      rd_data,
  input logic             trap
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> rd_data[31:18] == '0);

  a_r2_fav_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !rd_en && !rd_sel) |=> (rd_sel || rd_data[1] == $past(flt_addr_ok)));

  a_r3_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !rd_en) |=> (!rd_sel || rd_data == 32'($past(flt_addr))));

  a_r4_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(flt_valid));

  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && ctl_reg[QUIET_B] && flt_asi != ASI_W'(TRAP_ASI)) |=> !trap);

  a_r6_asi_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_asi == ASI_W'(TRAP_ASI)) |=> trap);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !flt_valid) |=> (rd_sel || rd_data == '0));
endmodule

bind fault_capture fault_capture_chk #(.AW(AW), .ASI_W(ASI_W), .TRAP_ASI(TRAP_ASI), .QUIET_B(QUIET_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_addr(flt_addr),
  .flt_addr_ok(flt_addr_ok), .flt_asi(flt_asi), .ctl_reg(ctl_reg),
  .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .trap(trap)
);

// File: tb/sim_fault_capture.sv
module sim_fault_capture;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        flt_valid = 0;
  logic [1:0]  flt_level = 0;
  logic [2:0]  flt_acc = 0;
  logic [2:0]  flt_kind = 0;
  logic [7:0]  flt_bus = 0;
  logic [31:0] flt_addr = 0;
  logic        flt_addr_ok = 0;
  logic [7:0]  flt_asi = 0;
  logic [31:0] ctl_reg = 0;
  logic        rd_en = 0;
  logic        rd_sel = 0;
  logic [31:0] rd_data;
  logic        trap;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fault_capture u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  longint m_fsr, m_far;
  bit m_pend, m_trap;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_fsr = 0; m_far = 0; m_pend = 0; m_trap = 0;
    end else begin
      m_trap = flt_valid && (ctl_reg[1] == 0 || flt_asi == 9);
      if (flt_valid) begin
        m_fsr = flt_bus * 1024 + flt_level * 256 + flt_acc * 32 + flt_kind * 4
              + flt_addr_ok * 2 + ((m_pend && !(rd_en && !rd_sel)) ? 1 : 0);
        m_far = flt_addr;
        m_pend = 1;
      end else if (rd_en && !rd_sel) begin
        m_fsr = 0; m_pend = 0;
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
    chk("R4 trap", trap, m_trap);
    chk("R2 read data", rd_data, rd_sel ? m_far : m_fsr);
  endtask

  task automatic fault(input logic [7:0] bus, input logic [1:0] lv, input logic [2:0] ac,
                       input logic [2:0] kd, input logic ok, input logic [31:0] a,
                       input logic [7:0] asi);
    flt_valid = 1; flt_bus = bus; flt_level = lv; flt_acc = ac; flt_kind = kd;
    flt_addr_ok = ok; flt_addr = a; flt_asi = asi;
    cyc();
    flt_valid = 0;
  endtask

  task automatic peek(input logic sel, string req, longint exp);
    rd_sel = sel; #1;
    chk(req, rd_data, exp);
    rd_sel = 0; #1;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    peek(0, "R1 status after reset", 0);
    peek(1, "R1 address after reset", 0);
    chk("R1 trap after reset", trap, 0);

    fault(8'hA5, 2, 5, 3, 1, 32'hDEAD_B000, 8'h0B);
    peek(0, "R2 packed status", 32'h0002_96AE);
    chk("R4 trap pulse high", trap, 1);
    cyc();
    chk("R4 trap pulse single", trap, 0);
    peek(1, "R3 address captured", 32'hDEAD_B000);

    fault(8'h00, 3, 0, 1, 0, 32'h1234_5678, 8'h0B);
    peek(0, "R7 overwrite with newest", 32'h0000_0305);

    rd_en = 1; rd_sel = 0; #1;
    chk("R8 read returns value", rd_data, 32'h0000_0305);
    cyc();
    rd_en = 0;
    peek(0, "R8 status cleared", 0);
    peek(1, "R8 address kept", 32'h1234_5678);

    ctl_reg = 32'h0000_0002;
    fault(8'h01, 1, 2, 2, 1, 32'h0000_4440, 8'h20);
    chk("R5 no trap in quiet mode", trap, 0);
    peek(0, "R5 status still updated", 32'h0000_054A);
    peek(1, "R5 address still updated", 32'h0000_4440);
    cyc();
    chk("R5 no trap later", trap, 0);

    fault(8'h00, 0, 7, 6, 1, 32'h0000_9990, 8'h09);
    chk("R6 ASI 9 traps in quiet mode", trap, 1);
    peek(0, "R7 overwrite set", 32'h0000_00FB);

    rd_en = 1;
    fault(8'h00, 0, 1, 4, 0, 32'h0000_0040, 8'h00);
    rd_en = 0;
    peek(0, "R9 coincident fault has OW 0", 32'h0000_0030);

    rd_en = 1; rd_sel = 1;
    cyc();
    rd_en = 0; rd_sel = 0;
    peek(0, "R10 address read keeps status", 32'h0000_0030);
    fault(8'h00, 0, 1, 4, 0, 32'h0000_0080, 8'h00);
    peek(0, "R9 R10 next fault sets OW", 32'h0000_0031);

    lf = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      flt_valid = lf[0] | lf[5];
      flt_bus = lf[15:8]; flt_level = lf[17:16]; flt_acc = lf[20:18];
      flt_kind = lf[23:21]; flt_addr_ok = lf[24]; flt_addr = lf ^ 32'h5A5A_0000;
      flt_asi = lf[25] ? 8'h09 : {4'h0, lf[29:26]};
      ctl_reg = {30'h0, lf[30], 1'b0};
      rd_en = lf[3]; rd_sel = lf[4] & lf[6];
      cyc();
    end
    flt_valid = 0; rd_en = 0; rd_sel = 0;
    cyc();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule